// File: doc/BRIEF.md
# Instruction decode-and-execute unit

This unit sits between the register read ports and the register write port of a small 32-bit load/store processor core. Each cycle it receives one fixed-format instruction word plus the two operand values that the surrounding logic has already read from the register file. It decodes the word and computes the result for a small integer subset: add, bitwise OR, signed set-less-than, constant-amount logical shifts, add-immediate and upper-immediate load. It then reports which register receives the result and whether that write should happen.

Register-form instructions carry a zero major opcode and pick their operation from a six-bit function code. Immediate-form instructions carry a 16-bit constant in the low half of the word. Any encoding outside the subset is flagged as illegal and never writes. Writes aimed at register index 0 are dropped, so that register stays zero. All decode and arithmetic is combinational. A parameter chooses whether the outputs pass through one register stage (the default) or leave the block directly.

Top module: `instr_exec_unit`

## Requirements
- R1: Register form (bits [31:26] = 0) with function code (bits [5:0]) 32 yields the 32-bit wrapping sum of the first and second operand values.
- R2: Register form with function code 37 yields the bitwise OR of the two operand values.
- R3: Register form with function code 42 yields 1 when the first operand is less than the second as signed two's-complement values, otherwise 0.
- R4: Register form with function code 0 yields the second operand shifted left by the amount in bits [10:6]. The first operand value and the source index field [25:21] have no effect.
- R5: Register form with function code 2 yields the second operand shifted right by bits [10:6], with zeros filling the top. The first operand value has no effect.
- R6: Opcode 8 yields the first operand plus bits [15:0] sign-extended to 32 bits. The destination is the index in bits [20:16].
- R7: Opcode 15 yields bits [15:0] placed in result bits [31:16] with bits [15:0] cleared. The first operand value has no effect, and the destination is bits [20:16].
- R8: For register forms, the destination index is bits [15:11].
- R9: A legal instruction whose destination index is 0 drives the write enable low. Every legal instruction with a nonzero destination drives it high.
- R10: Any opcode other than 0, 8 and 15, and any register-form function code other than 0, 2, 32, 37 and 42, raises the illegal flag and drives write enable, destination and result to 0.
- R11: With the output stage enabled, all outputs reflect the inputs present at the previous rising clock edge. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named by bits [25:21] |
| rt_val_i | input | 32 | Value of the register named by bits [20:16] |
| result_o | output | 32 | Computed result |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Unsupported encoding flag |

## Verification
With the default registered build, every output is due exactly one rising edge after the instruction and operands are applied. No output is due earlier. The bench changes inputs on a falling edge, waits through one rising edge and samples on the following falling edge, half a period clear of any update. One dedicated check samples a few nanoseconds after new inputs are applied, before the next rising edge, and expects the previous instruction's outputs to be unchanged. The reset check samples on falling edges while reset is held.

// File: rtl/iex_pkg.sv
`timescale 1ns/1ps
package iex_pkg;

    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int SHAMT_W   = 5;
    localparam int IMM_W     = 16;
    localparam int OPC_W     = 6;
    localparam int FN_W      = 6;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_SLT,
        OP_SLL,
        OP_SRL,
        OP_ADDI,
        OP_LUI,
        OP_NONE
    } iex_op_e;

    typedef struct packed {
        iex_op_e                op;
        logic [REG_IDX_W-1:0]   dest;
        logic                   wr_en;
        logic                   illegal;
    } iex_dec_t;

    typedef struct packed {
        logic [XLEN-1:0]        result;
        logic [REG_IDX_W-1:0]   dest;
        logic                   wr_en;
        logic                   illegal;
    } iex_out_t;

endpackage

// File: rtl/iex_decoder.sv
`timescale 1ns/1ps
module iex_decoder
    import iex_pkg::*;
(
    input  logic [OPC_W-1:0]     opc_i,
    input  logic [FN_W-1:0]      fn_i,
    input  logic [REG_IDX_W-1:0] rt_idx_i,
    input  logic [REG_IDX_W-1:0] rd_idx_i,
    output iex_dec_t             dec_o
);

    iex_op_e               op_sel;
    logic                  bad_enc;
    logic                  reg_form;
    logic [REG_IDX_W-1:0]  dest_raw;

    // opcode / function code classification
    always_comb begin
        op_sel  = OP_NONE;
        bad_enc = 1'b0;
        case (opc_i)
            OPC_REG: begin
                case (fn_i)
                    FN_ADD:  op_sel = OP_ADD;
                    FN_OR:   op_sel = OP_OR;
                    FN_SLT:  op_sel = OP_SLT;
                    FN_SLL:  op_sel = OP_SLL;
                    FN_SRL:  op_sel = OP_SRL;
                    default: bad_enc = 1'b1;
                endcase
            end
            OPC_ADDI: op_sel  = OP_ADDI;
            OPC_LUI:  op_sel  = OP_LUI;
            default:  bad_enc = 1'b1;
        endcase
    end

    assign reg_form = (opc_i == OPC_REG);
    assign dest_raw = reg_form ? rd_idx_i : rt_idx_i;

    // destination selection and write qualification
    always_comb begin
        dec_o.op      = op_sel;
        dec_o.illegal = bad_enc;
        if (bad_enc) begin
            dec_o.dest  = '0;
            dec_o.wr_en = 1'b0;
        end else begin
            dec_o.dest  = dest_raw;
            dec_o.wr_en = (dest_raw != '0);
        end
    end

endmodule

// File: rtl/iex_datapath.sv
`timescale 1ns/1ps
module iex_datapath
    import iex_pkg::*;
(
    input  iex_op_e            op_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [XLEN-1:0]    rs_val_i,
    input  logic [XLEN-1:0]    rt_val_i,
    output logic [XLEN-1:0]    result_o
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_upper;
    logic [XLEN-1:0] add_b;
    logic [XLEN-1:0] sum;
    logic            lt_signed;

    assign imm_sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_upper = {imm_i, {EXT_W{1'b0}}};

    // one adder serves both the register and the immediate add
    assign add_b     = (op_i == OP_ADDI) ? imm_sext : rt_val_i;
    assign sum       = rs_val_i + add_b;
    assign lt_signed = ($signed(rs_val_i) < $signed(rt_val_i));

    always_comb begin
        case (op_i)
            OP_ADD,
            OP_ADDI: result_o = sum;
            OP_OR:   result_o = rs_val_i | rt_val_i;
            OP_SLT:  result_o = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLL:  result_o = rt_val_i << shamt_i;
            OP_SRL:  result_o = rt_val_i >> shamt_i;
            OP_LUI:  result_o = imm_upper;
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/iex_out_stage.sv
`timescale 1ns/1ps
module iex_out_stage
    import iex_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  iex_out_t out_d,
    output iex_out_t out_q
);

    generate
        if (REGISTERED) begin : g_reg
            iex_out_t stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= out_d;
            end
            assign out_q = stage_q;
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign out_q = out_d;
        end
    endgenerate

endmodule

// File: rtl/instr_exec_unit.sv
`timescale 1ns/1ps
module instr_exec_unit
    import iex_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          instr_i,
    input  logic [XLEN-1:0]      rs_val_i,
    input  logic [XLEN-1:0]      rt_val_i,
    output logic [XLEN-1:0]      result_o,
    output logic [REG_IDX_W-1:0] dest_o,
    output logic                 wr_en_o,
    output logic                 illegal_o
);

    // fixed field slices of the instruction word
    logic [OPC_W-1:0]     f_opc;
    logic [REG_IDX_W-1:0] f_rt;
    logic [REG_IDX_W-1:0] f_rd;
    logic [SHAMT_W-1:0]   f_shamt;
    logic [FN_W-1:0]      f_fn;
    logic [IMM_W-1:0]     f_imm;
    logic [REG_IDX_W-1:0] unused_rs_idx;

    assign f_opc         = instr_i[31:26];
    assign unused_rs_idx = instr_i[25:21];
    assign f_rt          = instr_i[20:16];
    assign f_rd          = instr_i[15:11];
    assign f_shamt       = instr_i[10:6];
    assign f_fn          = instr_i[5:0];
    assign f_imm         = instr_i[15:0];

    iex_dec_t        dec;
    logic [XLEN-1:0] alu_res;
    iex_out_t        out_d;
    iex_out_t        out_q;

    iex_decoder u_dec (
        .opc_i    (f_opc),
        .fn_i     (f_fn),
        .rt_idx_i (f_rt),
        .rd_idx_i (f_rd),
        .dec_o    (dec)
    );

    iex_datapath u_dp (
        .op_i     (dec.op),
        .shamt_i  (f_shamt),
        .imm_i    (f_imm),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .result_o (alu_res)
    );

    always_comb begin
        out_d.result  = dec.illegal ? '0 : alu_res;
        out_d.dest    = dec.dest;
        out_d.wr_en   = dec.wr_en;
        out_d.illegal = dec.illegal;
    end

    iex_out_stage #(.REGISTERED(OUT_REG)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .out_d (out_d),
        .out_q (out_q)
    );

    assign result_o  = out_q.result;
    assign dest_o    = out_q.dest;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;

endmodule

// File: rtl/iex_checker.sv
`timescale 1ns/1ps
module iex_checker
    import iex_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OPC_W-1:0]     opc_i,
    input logic [FN_W-1:0]      fn_i,
    input logic [REG_IDX_W-1:0] rt_i,
    input logic [REG_IDX_W-1:0] rd_i,
    input logic [XLEN-1:0]      result_o,
    input logic [REG_IDX_W-1:0] dest_o,
    input logic                 wr_en_o,
    input logic                 illegal_o
);

    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (dest_o != '0)); // R9

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && dest_o == '0 && result_o == '0)); // R10

    generate
        if (OUT_REG) begin : g_seq
            AST_BAD_OPC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opc_i) != OPC_REG && $past(opc_i) != OPC_ADDI
                 && $past(opc_i) != OPC_LUI) |-> illegal_o); // R10

            AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opc_i) == OPC_LUI)
                |-> (result_o[15:0] == '0 && !illegal_o)); // R7

            AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opc_i) == OPC_REG && $past(fn_i) == FN_SLT)
                |-> (result_o[XLEN-1:1] == '0)); // R3

            AST_RFORM_DEST: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opc_i) == OPC_REG && $past(fn_i) == FN_ADD
                 && $past(rd_i) != '0) |-> (wr_en_o && dest_o == $past(rd_i))); // R8

            AST_IFORM_DEST: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opc_i) == OPC_ADDI && $past(rt_i) != '0)
                |-> (wr_en_o && dest_o == $past(rt_i))); // R6
        end
    endgenerate

endmodule

bind instr_exec_unit iex_checker #(.OUT_REG(OUT_REG)) u_iex_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opc_i     (instr_i[31:26]),
    .fn_i      (instr_i[5:0]),
    .rt_i      (instr_i[20:16]),
    .rd_i      (instr_i[15:11]),
    .result_o  (result_o),
    .dest_o    (dest_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o)
);

// File: tb/sim_instr_exec_unit.sv
`timescale 1ns/1ps
module sim_instr_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    instr_exec_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .rs_val_i  (rs_val),
        .rt_val_i  (rt_val),
        .result_o  (result),
        .dest_o    (dest),
        .wr_en_o   (wr_en),
        .illegal_o (illegal)
    );

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hFFFF_0000;
            default: return 32'h0000_00FF;
        endcase
    endfunction

    function automatic logic [31:0] rform(logic [4:0] s, logic [4:0] t, logic [4:0] d,
                                          logic [4:0] sh, logic [5:0] fn);
        return {6'd0, s, t, d, sh, fn};
    endfunction

    function automatic logic [31:0] iform(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                          logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    // expected outputs straight from the requirement text
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] er, output logic [4:0] ed,
                         output logic ew, output logic ei);
        logic [5:0]  op = ins[31:26];
        logic [5:0]  fn = ins[5:0];
        logic [4:0]  sh = ins[10:6];
        logic [15:0] im = ins[15:0];
        ei = 1'b0;
        er = '0;
        ed = '0;
        if (op == 6'd0) begin
            ed = ins[15:11];
            if (fn == 6'd32)      er = a + b;
            else if (fn == 6'd37) er = a | b;
            else if (fn == 6'd42) er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            else if (fn == 6'd0)  er = b << sh;
            else if (fn == 6'd2)  er = b >> sh;
            else                  ei = 1'b1;
        end else if (op == 6'd8) begin
            ed = ins[20:16];
            er = a + {{16{im[15]}}, im};
        end else if (op == 6'd15) begin
            ed = ins[20:16];
            er = {im, 16'h0000};
        end else begin
            ei = 1'b1;
        end
        if (ei) begin
            er = '0;
            ed = '0;
        end
        ew = !ei && (ed != 5'd0);
    endtask

    task automatic check(input string req, input logic [31:0] er, input logic [4:0] ed,
                         input logic ew, input logic ei);
        checks++;
        if (result !== er || dest !== ed || wr_en !== ew || illegal !== ei) begin
            errors++;
            $display("FAIL %s: got res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
                     req, result, dest, wr_en, illegal, er, ed, ew, ei);
        end
    endtask

    // drive on a falling edge, result due after the next rising edge
    task automatic run(input string req, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [4:0]  ed;
        logic        ew;
        logic        ei;
        instr  = ins;
        rs_val = a;
        rt_val = b;
        @(posedge clk);
        @(negedge clk);
        model(ins, a, b, er, ed, ew, ei);
        check(req, er, ed, ew, ei);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: outputs cleared while reset is held, even with a legal input present
        instr  = rform(5'd1, 5'd2, 5'd3, 5'd0, 6'd32);
        rs_val = 32'd5;
        rt_val = 32'd6;
        repeat (3) @(negedge clk);
        check("R11 reset", 32'd0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 add, R2 or, R3 signed compare over operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run("R1 add", rform(5'(i), 5'(j), 5'(i + j + 1), 5'd0, 6'd32), pat(i), pat(j));
                run("R2 or",  rform(5'(i), 5'(j), 5'(9 + i),     5'd0, 6'd37), pat(i), pat(j));
                run("R3 slt", rform(5'(i), 5'(j), 5'(17 + j),    5'd0, 6'd42), pat(i), pat(j));
            end
        end

        // R4 / R5 every shift amount, source value and index varied
        for (int s = 0; s < 32; s++) begin
            run("R4 sll", rform(5'(31 - s), 5'd4, 5'd6, 5'(s), 6'd0),
                pat(s % 8), 32'hF000_000F ^ pat(s % 8));
            run("R5 srl", rform(5'(s), 5'd4, 5'd7, 5'(s), 6'd2),
                pat((s + 3) % 8), 32'hF000_000F);
        end

        // R4 / R5 first operand has no effect
        run("R4 sll rs ignored", rform(5'd9, 5'd4, 5'd6, 5'd3, 6'd0), 32'hDEAD_BEEF, 32'h0000_0011);
        run("R5 srl rs ignored", rform(5'd9, 5'd4, 5'd6, 5'd3, 6'd2), 32'hDEAD_BEEF, 32'h8800_0000);

        // R6 add-immediate with positive and negative constants
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 8; k++) begin
                run("R6 addi", iform(6'd8, 5'd3, 5'(k + 1), pat(k)[15:0] ^ 16'(k * 4099)),
                    pat(i), 32'hAAAA_5555);
            end
        end

        // R7 upper-immediate load, first operand garbage
        for (int k = 0; k < 8; k++) begin
            run("R7 lui", iform(6'd15, 5'(k), 5'(20 + k), 16'(pat(k) ^ 32'h0000_B3A0)),
                pat(7 - k), pat(k));
        end

        // R8 every destination index in register form
        for (int d = 0; d < 32; d++) begin
            run("R8 dest", rform(5'd1, 5'd2, 5'(d), 5'd0, 6'd32), 32'd100, 32'd23);
        end

        // R9 destination 0 suppresses the write
        run("R9 add rd0",  rform(5'd3, 5'd4, 5'd0, 5'd0, 6'd32), 32'd7, 32'd8);
        run("R9 addi rt0", iform(6'd8, 5'd3, 5'd0, 16'h0010), 32'd1, 32'd2);
        run("R9 lui rt0",  iform(6'd15, 5'd3, 5'd0, 16'h1234), 32'd1, 32'd2);

        // R10 every unsupported opcode
        for (int op = 1; op < 64; op++) begin
            if (op != 8 && op != 15)
                run("R10 opcode", iform(6'(op), 5'd3, 5'd4, 16'h1234), 32'd11, 32'd22);
        end

        // R10 every unsupported function code
        for (int fn = 0; fn < 64; fn++) begin
            if (fn != 0 && fn != 2 && fn != 32 && fn != 37 && fn != 42)
                run("R10 funct", rform(5'd3, 5'd4, 5'd7, 5'd2, 6'(fn)), 32'd11, 32'd22);
        end

        // R11 latency: new inputs are not visible before the next rising edge
        run("R11 setup", rform(5'd1, 5'd2, 5'd5, 5'd0, 6'd32), 32'd40, 32'd2);
        instr  = rform(5'd1, 5'd2, 5'd6, 5'd0, 6'd37);
        rs_val = 32'h0F00_0000;
        rt_val = 32'h0000_00F0;
        #5;
        check("R11 hold", 32'd42, 5'd5, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R11 update", 32'h0F00_00F0, 5'd6, 1'b1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule